// File: doc/BRIEF.md
# Single-Shot ADC Conversion Sequencer

This block runs exactly one software-requested conversion on a converter that multiplexes sixteen analog inputs. When the host raises a request, the block captures the channel number, the external-delay option and two current-source settings given in microamps. It turns the two settings into 2-bit codes and then drives the converter through a fixed order: force the converter on, enable software conversion on the chosen channel, unmask end-of-conversion, and issue a one-cycle start.

It then waits for end-of-conversion. A cycle counter bounds the wait, at five seconds by default. On completion it reads the 12-bit result in two byte reads and undoes its enables in two steps. It reports the outcome with a one-cycle done pulse, an error code and the held result.

Only one request is handled at a time. A request that arrives while one is in progress is not queued. A request whose channel number is out of range ends at once with an error and never touches the converter.

Top module: `adc_oneshot_seq`

## Requirements
- R1: While reset is held, `busy`, `done`, `err_code`, `result` and every converter-side output are zero.
- R2: The channel-0 current-source code on `adc_isrc0` is 0 for a request of at most 1 µA, 1 for at most 5 µA, 2 for at most 15 µA, and 3 for anything larger.
- R3: The channel-3 current-source code on `adc_isrc3` is 0 for at most 1 µA, 1 for at most 10 µA, 2 for at most 400 µA, and 3 for anything larger.
- R4: In the cycle after a valid request is accepted, `adc_force_on`, `adc_ext_delay` and both codes are driven. One cycle later `adc_sw_en` rises together with `adc_chan_sel`. One cycle after that `adc_eoc_unmask` rises, and in the next cycle `adc_start` is high for exactly one cycle.
- R5: `adc_eoc` is acted on only in the cycles after the start pulse while the block waits. At any other time it has no effect on any output. `adc_eoc_unmask` stays high from its rise until teardown.
- R6: After end-of-conversion the block asserts `adc_rd_en` for two cycles, with `adc_rd_hi` = 0 (low byte) and then `adc_rd_hi` = 1 (high byte). `result` becomes {high byte bits 3:0, low byte}, and the upper four bits of the high byte are ignored.
- R7: Teardown first clears `adc_sw_en`, `adc_chan_sel` and `adc_eoc_unmask` while `adc_force_on` stays high for one more cycle. It then clears `adc_force_on` and both current-source codes.
- R8: If `adc_eoc` does not arrive within `TIMEOUT_CYC` waiting cycles, no reads are made, teardown runs, `err_code` becomes 2 and `result` is 0. An end-of-conversion in the last waiting cycle still counts as success.
- R9: A request with a channel number above 15 produces `done` with `err_code` = 1 in the next cycle, with `result` 0 and no converter-side output ever raised.
- R10: `busy` is high from the cycle after acceptance up to and including the done cycle. A request raised while `busy` is high is ignored, and a request held high is accepted in the first cycle after `done`.
- R11: `done` is a single-cycle pulse. `err_code` is 0 after a successful conversion, and `err_code` and `result` hold until the next request is accepted, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Conversion request, sampled only while idle |
| req_chan | input | 5 | Requested channel; values above 15 are rejected |
| req_isrc0_ua | input | 16 | Channel-0 current-source request in µA |
| req_isrc3_ua | input | 16 | Channel-3 current-source request in µA |
| req_ext_delay | input | 1 | External-delay option for this conversion |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 bad channel, 2 timeout |
| result | output | 12 | Converted code, held |
| adc_force_on | output | 1 | Keeps the converter state machine powered |
| adc_ext_delay | output | 1 | External-delay option to the converter |
| adc_isrc0 | output | 2 | Channel-0 current-source code |
| adc_isrc3 | output | 2 | Channel-3 current-source code |
| adc_sw_en | output | 1 | Software conversion enable |
| adc_chan_sel | output | 4 | Input multiplexer select |
| adc_eoc_unmask | output | 1 | End-of-conversion interrupt unmask |
| adc_start | output | 1 | One-cycle start strobe |
| adc_eoc | input | 1 | End-of-conversion from the converter |
| adc_rd_en | output | 1 | Result byte read strobe |
| adc_rd_hi | output | 1 | 0 selects the low byte, 1 the high byte |
| adc_rd_data | input | 8 | Result byte returned in the same cycle |

## Verification
The assertions take for granted that `adc_rd_data` carries the selected byte in the same cycle that `adc_rd_en` is high. They also assume that `adc_eoc` may be high at any time without harm, and that the host may hold `req_valid` high across a completion. The converter stub in the bench answers reads combinationally from the selected byte, and it puts junk in the unused high nibble. It raises end-of-conversion on a waiting cycle that the bench chooses per request, or never. Separate stray pulses of `adc_eoc` are injected while the block is idle and during preparation, to show that they are ignored.

// File: rtl/adc_seq_pkg.sv
// Shared types for the single-shot conversion sequencer.
// Assumes: one sequencer instance per converter; codes below are visible at the top ports.
package adc_seq_pkg;

    // Sequencer phases, one per converter-side step
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREP,
        ST_ENABLE,
        ST_UNMASK,
        ST_START,
        ST_WAIT,
        ST_RD_LO,
        ST_RD_HI,
        ST_TEAR_SEL,
        ST_TEAR_FORCE,
        ST_DONE
    } seq_state_t;

    // Outcome codes reported on err_code
    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_BADCH   = 2'd1,
        ERR_TIMEOUT = 2'd2
    } seq_err_t;

endpackage

// File: rtl/adc_isrc_enc.sv
// Maps a current request in microamps onto a 2-bit current-source code.
// Assumes: STEP0 < STEP1 < STEP2; purely combinational, sampled by the sequencer on accept.
module adc_isrc_enc #(
    parameter int unsigned UA_W  = 16,
    parameter int unsigned STEP0 = 1,
    parameter int unsigned STEP1 = 5,
    parameter int unsigned STEP2 = 15
) (
    input  logic [UA_W-1:0] ua,
    output logic [1:0]      code
);

    // Pick the smallest bucket whose upper bound covers the request
    always_comb begin
        if (ua <= UA_W'(STEP0))
            code = 2'd0;
        else if (ua <= UA_W'(STEP1))
            code = 2'd1;
        else if (ua <= UA_W'(STEP2))
            code = 2'd2;
        else
            code = 2'd3;
    end

endmodule

// File: rtl/adc_conv_timer.sv
// Counts waiting cycles and flags the last permitted one.
// Assumes: run is held high only while the sequencer waits for end-of-conversion,
// and the sequencer leaves the wait no later than the cycle expired is raised.
module adc_conv_timer #(
    parameter int unsigned LIMIT = 500_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry is the final waiting cycle
    assign expired = run && (cnt_q == LAST);

    // Count while running, clear as soon as the wait ends
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R8
    expired_leaves_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !run);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Phase sequencer: accepts a request, steps the converter through preparation,
// start, bounded wait, two byte reads and two-step teardown, then reports.
// Assumes: adc_rd_data is valid in the same cycle as adc_rd_en; tmo_expired comes
// from a timer that runs only while this block is in the waiting phase.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned CH_IN_W = 5,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned RES_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [CH_IN_W-1:0] req_chan,
    input  logic [1:0]         req_code0,
    input  logic [1:0]         req_code3,
    input  logic               req_ext_delay,
    input  logic               adc_eoc,
    input  logic [BYTE_W-1:0]  adc_rd_data,
    input  logic               tmo_expired,
    output logic               tmo_run,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err_code,
    output logic [RES_W-1:0]   result,
    output logic               adc_force_on,
    output logic               adc_ext_delay,
    output logic [1:0]         adc_isrc0,
    output logic [1:0]         adc_isrc3,
    output logic               adc_sw_en,
    output logic [SEL_W-1:0]   adc_chan_sel,
    output logic               adc_eoc_unmask,
    output logic               adc_start,
    output logic               adc_rd_en,
    output logic               adc_rd_hi
);

    localparam int unsigned HI_W   = RES_W - BYTE_W;
    localparam int unsigned NUM_CH = 1 << SEL_W;
    localparam logic [CH_IN_W-1:0] MAX_CH = CH_IN_W'(NUM_CH - 1);

    seq_state_t         state_q, state_d;
    logic [SEL_W-1:0]   lat_chan;
    logic [1:0]         lat_code0, lat_code3;
    logic               lat_ext;
    logic [BYTE_W-1:0]  res_lo;
    logic [HI_W-1:0]    res_hi;
    seq_err_t           err_q;
    logic               timed_out;
    logic               accept;
    logic               chan_bad;
    logic               cfg_on, sel_on, irq_on;

    // A request is taken only in the idle phase
    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign chan_bad = req_chan > MAX_CH;

    // Next phase of the fixed conversion order
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = chan_bad ? ST_DONE : ST_PREP;
            ST_PREP:       state_d = ST_ENABLE;
            ST_ENABLE:     state_d = ST_UNMASK;
            ST_UNMASK:     state_d = ST_START;
            ST_START:      state_d = ST_WAIT;
            ST_WAIT: begin
                if (adc_eoc)
                    state_d = ST_RD_LO;
                else if (tmo_expired)
                    state_d = ST_TEAR_SEL;
            end
            ST_RD_LO:      state_d = ST_RD_HI;
            ST_RD_HI:      state_d = ST_TEAR_SEL;
            ST_TEAR_SEL:   state_d = ST_TEAR_FORCE;
            ST_TEAR_FORCE: state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Request settings captured on accept and held for the whole conversion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_chan  <= '0;
            lat_code0 <= '0;
            lat_code3 <= '0;
            lat_ext   <= 1'b0;
        end else if (accept && !chan_bad) begin
            lat_chan  <= req_chan[SEL_W-1:0];
            lat_code0 <= req_code0;
            lat_code3 <= req_code3;
            lat_ext   <= req_ext_delay;
        end
    end

    // Result bytes: cleared on accept, filled by the two reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (accept) begin
            res_lo <= '0;
            res_hi <= '0;
        end else if (state_q == ST_RD_LO) begin
            res_lo <= adc_rd_data;
        end else if (state_q == ST_RD_HI) begin
            res_hi <= adc_rd_data[HI_W-1:0];
        end
    end

    // Outcome tracking: timeout noted in the wait, code published entering done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= ERR_NONE;
            timed_out <= 1'b0;
        end else if (accept) begin
            err_q     <= chan_bad ? ERR_BADCH : ERR_NONE;
            timed_out <= 1'b0;
        end else begin
            if (state_q == ST_WAIT && !adc_eoc && tmo_expired)
                timed_out <= 1'b1;
            if (state_q == ST_TEAR_FORCE)
                err_q <= timed_out ? ERR_TIMEOUT : ERR_NONE;
        end
    end

    // Group phases by which converter controls they hold
    always_comb begin
        cfg_on = state_q inside {ST_PREP, ST_ENABLE, ST_UNMASK, ST_START, ST_WAIT,
                                 ST_RD_LO, ST_RD_HI, ST_TEAR_SEL};
        sel_on = state_q inside {ST_ENABLE, ST_UNMASK, ST_START, ST_WAIT,
                                 ST_RD_LO, ST_RD_HI};
        irq_on = state_q inside {ST_UNMASK, ST_START, ST_WAIT, ST_RD_LO, ST_RD_HI};
    end

    // Converter-side and host-side outputs decoded from the phase
    always_comb begin
        adc_force_on   = cfg_on;
        adc_ext_delay  = cfg_on && lat_ext;
        adc_isrc0      = cfg_on ? lat_code0 : 2'd0;
        adc_isrc3      = cfg_on ? lat_code3 : 2'd0;
        adc_sw_en      = sel_on;
        adc_chan_sel   = sel_on ? lat_chan : '0;
        adc_eoc_unmask = irq_on;
        adc_start      = (state_q == ST_START);
        adc_rd_en      = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        adc_rd_hi      = (state_q == ST_RD_HI);
        tmo_run        = (state_q == ST_WAIT);
        busy           = (state_q != ST_IDLE);
        done           = (state_q == ST_DONE);
        err_code       = err_q;
        result         = {res_hi, res_lo};
    end

    // R4
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (adc_force_on && adc_sw_en && adc_eoc_unmask));

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R7
    sel_before_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_force_on) |-> (!$past(adc_sw_en) && !$past(adc_eoc_unmask)));

    // R5
    unmask_needs_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_eoc_unmask |-> adc_force_on);

    // R9
    badch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chan_bad) |=> (done && !adc_force_on && err_code == ERR_BADCH));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(lat_chan));

endmodule

// File: rtl/adc_oneshot_seq.sv
// Top of the single-shot conversion sequencer: current-source encoders, the
// end-of-conversion timeout counter and the phase sequencer.
// Assumes: CLK_HZ is the real clock rate; TIMEOUT_CYC may be overridden for short runs.
module adc_oneshot_seq #(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned TIMEOUT_MS  = 5000,
    parameter int unsigned TIMEOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS,
    parameter int unsigned UA_W        = 16,
    parameter int unsigned CH_IN_W     = 5,
    parameter int unsigned SEL_W       = 4,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned RES_W       = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [CH_IN_W-1:0] req_chan,
    input  logic [UA_W-1:0]    req_isrc0_ua,
    input  logic [UA_W-1:0]    req_isrc3_ua,
    input  logic               req_ext_delay,
    output logic               busy,
    output logic               done,
    output logic [1:0]         err_code,
    output logic [RES_W-1:0]   result,
    output logic               adc_force_on,
    output logic               adc_ext_delay,
    output logic [1:0]         adc_isrc0,
    output logic [1:0]         adc_isrc3,
    output logic               adc_sw_en,
    output logic [SEL_W-1:0]   adc_chan_sel,
    output logic               adc_eoc_unmask,
    output logic               adc_start,
    input  logic               adc_eoc,
    output logic               adc_rd_en,
    output logic               adc_rd_hi,
    input  logic [BYTE_W-1:0]  adc_rd_data
);

    logic [1:0] code0, code3;
    logic       tmo_run, tmo_expired;

    // Channel-0 source: 1 / 5 / 15 µA bucket bounds
    adc_isrc_enc #(.UA_W(UA_W), .STEP0(1), .STEP1(5), .STEP2(15)) u_enc0 (
        .ua   (req_isrc0_ua),
        .code (code0)
    );

    // Channel-3 source: 1 / 10 / 400 µA bucket bounds
    adc_isrc_enc #(.UA_W(UA_W), .STEP0(1), .STEP1(10), .STEP2(400)) u_enc3 (
        .ua   (req_isrc3_ua),
        .code (code3)
    );

    adc_conv_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .expired (tmo_expired)
    );

    adc_seq_ctrl #(
        .CH_IN_W (CH_IN_W),
        .SEL_W   (SEL_W),
        .BYTE_W  (BYTE_W),
        .RES_W   (RES_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_chan       (req_chan),
        .req_code0      (code0),
        .req_code3      (code3),
        .req_ext_delay  (req_ext_delay),
        .adc_eoc        (adc_eoc),
        .adc_rd_data    (adc_rd_data),
        .tmo_expired    (tmo_expired),
        .tmo_run        (tmo_run),
        .busy           (busy),
        .done           (done),
        .err_code       (err_code),
        .result         (result),
        .adc_force_on   (adc_force_on),
        .adc_ext_delay  (adc_ext_delay),
        .adc_isrc0      (adc_isrc0),
        .adc_isrc3      (adc_isrc3),
        .adc_sw_en      (adc_sw_en),
        .adc_chan_sel   (adc_chan_sel),
        .adc_eoc_unmask (adc_eoc_unmask),
        .adc_start      (adc_start),
        .adc_rd_en      (adc_rd_en),
        .adc_rd_hi      (adc_rd_hi)
    );

endmodule

// File: tb/adc_oneshot_seq_bench.sv
// Bench: converter stub plus a per-cycle expected-frame model built at request time.
module adc_oneshot_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BENCH_TMO  = 20;
    localparam int WATCHDOG   = 100000;

    logic        clk;
    logic        rst_n;
    logic        req_valid;
    logic [4:0]  req_chan;
    logic [15:0] req_isrc0_ua;
    logic [15:0] req_isrc3_ua;
    logic        req_ext_delay;
    logic        busy, done;
    logic [1:0]  err_code;
    logic [11:0] result;
    logic        adc_force_on, adc_ext_delay;
    logic [1:0]  adc_isrc0, adc_isrc3;
    logic        adc_sw_en;
    logic [3:0]  adc_chan_sel;
    logic        adc_eoc_unmask, adc_start, adc_eoc, adc_rd_en, adc_rd_hi;
    logic [7:0]  adc_rd_data;

    adc_oneshot_seq #(.TIMEOUT_CYC(BENCH_TMO)) u_adc_oneshot_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_isrc0_ua(req_isrc0_ua), .req_isrc3_ua(req_isrc3_ua),
        .req_ext_delay(req_ext_delay), .busy(busy), .done(done),
        .err_code(err_code), .result(result), .adc_force_on(adc_force_on),
        .adc_ext_delay(adc_ext_delay), .adc_isrc0(adc_isrc0), .adc_isrc3(adc_isrc3),
        .adc_sw_en(adc_sw_en), .adc_chan_sel(adc_chan_sel),
        .adc_eoc_unmask(adc_eoc_unmask), .adc_start(adc_start), .adc_eoc(adc_eoc),
        .adc_rd_en(adc_rd_en), .adc_rd_hi(adc_rd_hi), .adc_rd_data(adc_rd_data)
    );

    typedef struct packed {
        logic        busy;
        logic        done;
        logic [1:0]  err;
        logic [11:0] res;
        logic        force_on;
        logic        ext;
        logic [1:0]  i0;
        logic [1:0]  i3;
        logic        swen;
        logic [3:0]  sel;
        logic        unmask;
        logic        start;
        logic        rd_en;
        logic        rd_hi;
    } frame_t;

    frame_t      exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_accept = 0;
    int          cycles = 0;
    bit          cur_busy = 0;
    bit          cyc_bad = 0;
    bit          seen_edge = 0;
    logic [11:0] held_res = '0;
    logic [1:0]  held_err = '0;

    int          stub_delay = 0;
    logic [11:0] stub_val = '0;
    bit          stub_eoc = 0;
    bit          stray_eoc = 0;
    bit          armed = 0;
    int          wctr = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter stub: byte read answered combinationally, junk in the unused nibble (R6)
    assign adc_rd_data = adc_rd_hi ? {4'hA, stub_val[11:8]} : stub_val[7:0];
    assign adc_eoc     = stub_eoc | stray_eoc;

    // Converter stub: end-of-conversion on the chosen waiting cycle
    always @(negedge clk) begin
        if (armed) begin
            stub_eoc = (stub_delay >= 0) && (wctr == stub_delay);
            if (stub_eoc) armed = 0;
            wctr++;
        end else begin
            stub_eoc = 0;
        end
        if (adc_start === 1'b1) begin
            armed = 1;
            wctr  = 0;
        end
    end

    function automatic logic [1:0] enc0(input int ua);   // R2 bucket bounds
        if (ua <= 1) return 2'd0;
        if (ua <= 5) return 2'd1;
        if (ua <= 15) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [1:0] enc3(input int ua);   // R3 bucket bounds
        if (ua <= 1) return 2'd0;
        if (ua <= 10) return 2'd1;
        if (ua <= 400) return 2'd2;
        return 2'd3;
    endfunction

    function automatic frame_t idle_frame();
        frame_t f;
        f     = '0;
        f.res = held_res;
        f.err = held_err;
        return f;
    endfunction

    // Expected frames of one whole request, one per clock cycle
    task automatic push_request(input logic [4:0] ch, input int ua0, input int ua3,
                                input logic ext);
        frame_t f, cfg, t;
        bit ok;
        int n;
        if (ch > 5'd15) begin                     // R9 rejected at once
            f = '0; f.busy = 1; f.done = 1; f.err = 2'd1;
            exp_q.push_back(f);
            held_res = '0; held_err = 2'd1;
            return;
        end
        cfg = '0; cfg.busy = 1; cfg.force_on = 1; cfg.ext = ext;
        cfg.i0 = enc0(ua0); cfg.i3 = enc3(ua3);
        f = cfg;                       exp_q.push_back(f);   // force on
        f.swen = 1; f.sel = ch[3:0];   exp_q.push_back(f);   // enable + select
        f.unmask = 1;                  exp_q.push_back(f);   // unmask
        f.start = 1;                   exp_q.push_back(f);   // start strobe
        f.start = 0;
        ok = (stub_delay >= 0) && (stub_delay < BENCH_TMO);
        n  = ok ? stub_delay + 1 : BENCH_TMO;
        for (int k = 0; k < n; k++) exp_q.push_back(f);      // wait
        if (ok) begin
            f.rd_en = 1;                                exp_q.push_back(f);
            f.rd_hi = 1; f.res = {4'h0, stub_val[7:0]}; exp_q.push_back(f);
        end
        t = cfg; t.res = ok ? stub_val : 12'h000;  exp_q.push_back(t);   // drop select
        t = '0; t.busy = 1; t.res = ok ? stub_val : 12'h000; exp_q.push_back(t); // drop force
        t.done = 1; t.err = ok ? 2'd0 : 2'd2;      exp_q.push_back(t);
        held_res = ok ? stub_val : 12'h000;
        held_err = ok ? 2'd0 : 2'd2;
    endtask

    // Model: accept on the same edge as the design would
    always @(posedge clk) begin
        seen_edge = 1;
        if (!rst_n) begin
            held_res = '0; held_err = '0;
            exp_q.delete();
        end else if (req_valid && !cur_busy) begin
            n_accept++;
            push_request(req_chan, int'(req_isrc0_ua), int'(req_isrc3_ua), req_ext_delay);
        end
    end

    task automatic chk(input string field, input string req, input int act, input int exp);
        if (act != exp) begin
            cyc_bad = 1;
            $display("FAIL %s %s at %0t: actual %0h expected %0h", req, field, $time, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the expected frame
    always @(negedge clk) begin
        frame_t e;
        if (seen_edge) begin
            if (!rst_n) e = idle_frame();
            else if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = idle_frame();
            cur_busy = e.busy;
            cyc_bad  = 0;
            chk("busy",      "R10", int'(busy),           int'(e.busy));
            chk("done",      "R11", int'(done),           int'(e.done));
            chk("err_code",  "R8_R9", int'(err_code),     int'(e.err));
            chk("result",    "R6",  int'(result),         int'(e.res));
            chk("force_on",  "R4",  int'(adc_force_on),   int'(e.force_on));
            chk("ext_delay", "R4",  int'(adc_ext_delay),  int'(e.ext));
            chk("isrc0",     "R2",  int'(adc_isrc0),      int'(e.i0));
            chk("isrc3",     "R3",  int'(adc_isrc3),      int'(e.i3));
            chk("sw_en",     "R7",  int'(adc_sw_en),      int'(e.swen));
            chk("chan_sel",  "R4",  int'(adc_chan_sel),   int'(e.sel));
            chk("unmask",    "R5",  int'(adc_eoc_unmask), int'(e.unmask));
            chk("start",     "R4",  int'(adc_start),      int'(e.start));
            chk("rd_en",     "R6",  int'(adc_rd_en),      int'(e.rd_en));
            chk("rd_hi",     "R6",  int'(adc_rd_hi),      int'(e.rd_hi));
            n_cmp++;
            if (cyc_bad) n_bad++;
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic drain();
        while (exp_q.size() != 0 || cur_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input logic [4:0] ch, input int ua0, input int ua3,
                          input logic ext, input int dly, input logic [11:0] val,
                          input bit stray, input bit poke);
        @(negedge clk);
        stub_delay    = dly;
        stub_val      = val;
        req_chan      = ch;
        req_isrc0_ua  = 16'(ua0);
        req_isrc3_ua  = 16'(ua3);
        req_ext_delay = ext;
        req_valid     = 1;
        if (stray) stray_eoc = 1;
        @(negedge clk);
        req_valid = 0;
        if (stray) begin
            repeat (2) @(negedge clk);
            stray_eoc = 0;
        end
        if (poke) begin                    // R10 requests while busy are ignored
            req_chan = 5'd3;
            while (exp_q.size() > 2) begin
                @(negedge clk);
                req_valid = ~req_valid;
            end
            req_valid = 0;
        end
        drain();
    endtask

    initial begin
        int first;
        rst_n = 0; req_valid = 0; req_chan = '0; req_isrc0_ua = '0;
        req_isrc3_ua = '0; req_ext_delay = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        n_cmp++;
        if (busy !== 1'b0 || done !== 1'b0 || err_code !== 2'd0 || result !== 12'd0 ||
            adc_force_on !== 1'b0 || adc_sw_en !== 1'b0 || adc_start !== 1'b0 ||
            adc_eoc_unmask !== 1'b0 || adc_rd_en !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual busy=%b force=%b result=%0h expected all zero",
                     busy, adc_force_on, result);
        end
        rst_n = 1;
        // R5 stray end-of-conversion while idle
        @(negedge clk); stray_eoc = 1;
        repeat (2) @(negedge clk); stray_eoc = 0;
        // R4 R6 basic conversion, lowest codes
        do_req(5'd5, 0, 0, 1'b0, 3, 12'hABC, 0, 0);
        // R2 R3 second bucket, ext delay, eoc in first waiting cycle
        do_req(5'd15, 5, 10, 1'b1, 0, 12'hFFF, 0, 0);
        // R2 R3 third bucket from just above the second bound; R5 stray eoc in prep
        do_req(5'd0, 6, 11, 1'b0, 7, 12'h001, 1, 0);
        // R2 R3 upper edge of third bucket
        do_req(5'd9, 15, 400, 1'b1, 2, 12'h5A5, 0, 0);
        // R2 R3 top bucket
        do_req(5'd12, 16, 401, 1'b0, 1, 12'h800, 0, 0);
        // R2 R3 edges of first and second buckets
        do_req(5'd1, 1, 1, 1'b0, 4, 12'h0F0, 0, 0);
        do_req(5'd2, 2, 2, 1'b1, 5, 12'h10E, 0, 0);
        do_req(5'd3, 65535, 65535, 1'b0, 2, 12'h777, 0, 0);
        // R8 timeout: no end-of-conversion at all
        do_req(5'd7, 3, 3, 1'b0, -1, 12'h123, 0, 0);
        // R8 end-of-conversion in the last permitted cycle still succeeds
        do_req(5'd8, 3, 3, 1'b0, BENCH_TMO - 1, 12'h321, 0, 0);
        // R8 one cycle too late
        do_req(5'd8, 3, 3, 1'b0, BENCH_TMO, 12'h456, 0, 0);
        // R9 out-of-range channels
        do_req(5'd16, 3, 3, 1'b1, 2, 12'h999, 0, 0);
        do_req(5'd31, 20, 500, 1'b0, 2, 12'h999, 0, 0);
        // R10 requests while busy are ignored
        do_req(5'd11, 4, 4, 1'b0, 6, 12'hC3C, 0, 1);
        // R10 R11 request held high: accepted again right after done
        @(negedge clk);
        stub_delay = 1; stub_val = 12'h2D2; req_chan = 5'd4;
        req_isrc0_ua = 16'd20; req_isrc3_ua = 16'd9; req_ext_delay = 1;
        first = n_accept;
        req_valid = 1;
        while (n_accept < first + 2) @(negedge clk);
        req_valid = 0;
        drain();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule